// File: doc/BRIEF.md
# Split-Operand Unsigned Wide Multiplier

This block multiplies two unsigned 32-bit operands into an exact 64-bit product. It does not use one wide multiply. Each operand is cut into an upper and a lower 16-bit half, and four half-width multipliers form the cross products of those halves. The three weight classes are then aligned and summed.

The partial product of the two lower halves has weight 1. The two mixed products each have weight 2^16. The product of the two upper halves has weight 2^32. The two mixed products are first added into a sum one bit wider than a partial product, so that their carry survives. That sum is then added to the concatenation of the top and bottom products.

In the default registered variant, the four partial products are held in a first register stage and the aligned sum in a second. A result therefore appears two clock edges after its operands. A new operand pair may be presented on every cycle. A parameter selects a purely combinational variant with no latency for use inside a larger pipeline.

Top module: `split_mul32`

## Requirements
- R1: `product` equals the exact unsigned product of `op_a` and `op_b` over all 64 bits, with nothing truncated.
- R2: `out_valid` goes high, with the matching `product`, exactly two rising edges after `in_valid` was sampled high. Results leave in the order their operands arrived, one per accepted pair.
- R3: `out_valid` is never high unless `in_valid` was sampled high two edges earlier.
- R4: `rst` is synchronous and active high. It clears both valid stages but no data register. `out_valid` is low in the cycle after `rst` is sampled high, and no result from before the reset appears after it is released.
- R5: A carry out of the 33-bit middle sum (upper-A times lower-B plus lower-A times upper-B) reaches bit 48 of the product. For example, all-ones times all-ones gives 0xFFFFFFFE_00000001.
- R6: An operand with a single set bit at a half boundary (bit 15, 16 or 31) gives the exact shifted copy of the other operand.
- R7: A zero in either operand gives a product of zero.
- R8: Operand pairs presented on consecutive cycles are all accepted without a stall. Each produces its own result on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Marks `op_a`/`op_b` as a pair to multiply |
| op_a | input | 32 | Unsigned multiplicand |
| op_b | input | 32 | Unsigned multiplier |
| out_valid | output | 1 | Marks `product` as a result |
| product | output | 64 | Unsigned full-width product |

## Verification
The operand patterns are chosen so that each one stresses a different part of the product assembly.

- A zero operand shows whether stale data leaks through the unreset data stages.
- All-ones operands drive the middle sum to its carry and expose a lost bit 48.
- A single bit at positions 15, 16 and 31 separates a wrong alignment shift from a wrong half selection.
- Half-patterns such as 0x0000FFFF against 0xFFFF0000 light exactly one cross product at a time.
- Random pairs sent back-to-back, and with gaps, check the ordering and the two-cycle timing of the result stream.

A reset issued while a pair is in flight confirms that the pair is dropped.

// File: rtl/split_mul_pkg.sv
package split_mul_pkg;

  // Index of a partial product in the four-entry array.
  // Bit 0 set: the upper half of A is used. Bit 1 set: the upper half of B is used.
  typedef enum logic [1:0] {
    PP_LL = 2'd0,
    PP_HL = 2'd1,
    PP_LH = 2'd2,
    PP_HH = 2'd3
  } pp_sel_e;

  localparam int unsigned PP_COUNT = 4;

  // Number of upper halves that take part in a partial product.
  // This sets its weight as a power of 2^HALF.
  function automatic int unsigned pp_weight(input pp_sel_e sel);
    logic [1:0] s;
    s = sel;
    return int'(s[0]) + int'(s[1]);
  endfunction

endpackage

// File: rtl/pp_mult.sv
module pp_mult #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   y,
  output logic [2*W-1:0] p
);

  function automatic logic [2*W-1:0] mul_half(input logic [W-1:0] a, input logic [W-1:0] b);
    return {{W{1'b0}}, a} * {{W{1'b0}}, b};
  endfunction

  assign p = mul_half(x, y);

endmodule

// File: rtl/pp_array.sv
module pp_array #(
  parameter int unsigned OP_W = 32
) (
  input  logic [OP_W-1:0]                                 op_a,
  input  logic [OP_W-1:0]                                 op_b,
  output logic [split_mul_pkg::PP_COUNT-1:0][OP_W-1:0]    pp
);

  localparam int unsigned HALF = OP_W / 2;

  logic [HALF-1:0] a_hi, a_lo, b_hi, b_lo;

  // Operand split: A = a_hi*2^HALF + a_lo, B = b_hi*2^HALF + b_lo
  assign a_hi = op_a[OP_W-1:HALF];
  assign a_lo = op_a[HALF-1:0];
  assign b_hi = op_b[OP_W-1:HALF];
  assign b_lo = op_b[HALF-1:0];

  for (genvar i = 0; i < int'(split_mul_pkg::PP_COUNT); i++) begin : g_pp
    localparam bit A_UP = (i % 2) == 1;
    localparam bit B_UP = (i / 2) == 1;
    logic [HALF-1:0] a_h, b_h;

    assign a_h = A_UP ? a_hi : a_lo;
    assign b_h = B_UP ? b_hi : b_lo;

    pp_mult #(.W(HALF)) u_mul (
      .x(a_h),
      .y(b_h),
      .p(pp[i])
    );
  end

endmodule

// File: rtl/pp_combine.sv
module pp_combine #(
  parameter int unsigned OP_W = 32
) (
  input  logic [split_mul_pkg::PP_COUNT-1:0][OP_W-1:0] pp,
  output logic [2*OP_W-1:0]                            product,
  output logic                                         mid_carry
);

  import split_mul_pkg::*;

  localparam int unsigned HALF   = OP_W / 2;
  localparam int unsigned PROD_W = 2 * OP_W;
  localparam int unsigned MID_W  = OP_W + 1;
  localparam int unsigned MID_SH = HALF * pp_weight(PP_HL);

  logic [MID_W-1:0]  mid_sum;
  logic [PROD_W-1:0] outer;
  logic [PROD_W-1:0] mid_aligned;

  // Middle sum is kept one bit wider so that its carry survives
  function automatic logic [MID_W-1:0] add_mid(input logic [OP_W-1:0] x, input logic [OP_W-1:0] y);
    return {1'b0, x} + {1'b0, y};
  endfunction

  // The top and bottom products never overlap, so they are simply concatenated
  function automatic logic [PROD_W-1:0] join_outer(input logic [OP_W-1:0] hh, input logic [OP_W-1:0] ll);
    return {hh, ll};
  endfunction

  assign mid_sum     = add_mid(pp[int'(PP_HL)], pp[int'(PP_LH)]);
  assign mid_carry   = mid_sum[MID_W-1];
  assign outer       = join_outer(pp[int'(PP_HH)], pp[int'(PP_LL)]);
  assign mid_aligned = {{(PROD_W-MID_W){1'b0}}, mid_sum} << MID_SH;
  assign product     = outer + mid_aligned;

endmodule

// File: rtl/split_mul32.sv
module split_mul32 #(
  parameter int unsigned OP_W       = 32,
  parameter bit          REGISTERED = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   op_a,
  input  logic [OP_W-1:0]   op_b,
  output logic              out_valid,
  output logic [2*OP_W-1:0] product
);

  import split_mul_pkg::*;

  localparam int unsigned HALF   = OP_W / 2;
  localparam int unsigned PROD_W = 2 * OP_W;

  logic [PP_COUNT-1:0][OP_W-1:0] pp_now;

  pp_array #(.OP_W(OP_W)) u_array (
    .op_a(op_a),
    .op_b(op_b),
    .pp  (pp_now)
  );

  if (REGISTERED) begin : g_pipe
    logic                          s1_valid;
    logic [PP_COUNT-1:0][OP_W-1:0] s1_pp;
    logic                          s2_valid;
    logic [PROD_W-1:0]             s2_prod;
    logic [PROD_W-1:0]             sum_now;
    logic                          mid_carry;

    pp_combine #(.OP_W(OP_W)) u_comb (
      .pp       (s1_pp),
      .product  (sum_now),
      .mid_carry(mid_carry)
    );

    // Valid pipeline: reset clears it
    always_ff @(posedge clk) begin
      if (rst) begin
        s1_valid <= 1'b0;
        s2_valid <= 1'b0;
      end else begin
        s1_valid <= in_valid;
        s2_valid <= s1_valid;
      end
    end

    // Data pipeline: no reset
    always_ff @(posedge clk) begin
      s1_pp   <= pp_now;
      s2_prod <= sum_now;
    end

    assign out_valid = s2_valid;
    assign product   = s2_prod;

    p_latency_r2 : assert property (@(posedge clk) disable iff (rst)
      in_valid |=> ##1 out_valid);

    p_no_spurious_r3 : assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(in_valid, 2));

    p_reset_clears_r4 : assert property (@(posedge clk)
      rst |=> !out_valid);

    p_mid_carry_r5 : assert property (@(posedge clk) disable iff (rst)
      (s1_valid && mid_carry) |-> (s1_pp[int'(PP_HL)] != '0 && s1_pp[int'(PP_LH)] != '0));

    p_low_half_r1 : assert property (@(posedge clk) disable iff (rst)
      s1_valid |=> (product[HALF-1:0] == $past(s1_pp[int'(PP_LL)][HALF-1:0])));

    p_zero_r7 : assert property (@(posedge clk) disable iff (rst)
      (in_valid && (op_a == '0 || op_b == '0)) |=> ##1 (product == '0));
  end else begin : g_comb
    logic mid_carry_unused;

    pp_combine #(.OP_W(OP_W)) u_comb (
      .pp       (pp_now),
      .product  (product),
      .mid_carry(mid_carry_unused)
    );

    assign out_valid = in_valid;
  end

endmodule

// File: tb/split_mul32_bench.sv
module split_mul32_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        out_valid;
  logic [63:0] product;

  int unsigned n_checks = 0;
  int unsigned n_fail   = 0;
  int unsigned cyc      = 0;
  bit          done     = 1'b0;

  logic [63:0] exp_q[$];
  int unsigned due_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  split_mul32 u_split_mul32 (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .op_a     (op_a),
    .op_b     (op_b),
    .out_valid(out_valid),
    .product  (product)
  );

  // Independent reference: shift-and-add over the bits of b
  function automatic logic [63:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
    logic [63:0] acc = '0;
    for (int i = 0; i < 32; i++)
      if (b[i]) acc = acc + ({32'd0, a} << i);
    return acc;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] a, input logic [31:0] b, input string tag);
    @(negedge clk);
    in_valid = 1'b1;
    op_a = a;
    op_b = b;
    if (!rst) begin
      exp_q.push_back(ref_mul(a, b));
      due_q.push_back(cyc + 2);
      tag_q.push_back(tag);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected out_valid", 64'(out_valid), 64'd0);
        end else begin
          logic [63:0] e;
          int unsigned d;
          string t;
          e = exp_q.pop_front();
          d = due_q.pop_front();
          t = tag_q.pop_front();
          check(product === e, t, product, e);
          check(cyc == d, "R2 latency", 64'(cyc), 64'(d));
        end
      end else if (due_q.size() != 0 && due_q[0] <= cyc) begin
        check(1'b0, "R2 missing result", 64'(out_valid), 64'd1);
        void'(exp_q.pop_front());
        void'(due_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R4: reset state
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R4 reset state", 64'(out_valid), 64'd0);
    rst = 1'b0;
    idle(2);

    // R7 zero operands
    drive(32'd0, 32'hDEAD_BEEF, "R7 zero a");
    drive(32'h1234_5678, 32'd0, "R7 zero b");
    // R5 middle carry with all ones
    drive(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5 all ones");
    // R6 single bits at half boundaries
    drive(32'h0000_8000, 32'hFFFF_FFFF, "R6 bit15");
    drive(32'h0001_0000, 32'hFFFF_FFFF, "R6 bit16");
    drive(32'h8000_0000, 32'h8000_0000, "R6 bit31");
    drive(32'hA5A5_5A5A, 32'h0001_0000, "R6 bit16 on b");
    // R1 half patterns: one cross product at a time
    drive(32'h0000_FFFF, 32'hFFFF_0000, "R1 lo x hi");
    drive(32'hFFFF_0000, 32'h0000_FFFF, "R1 hi x lo");
    drive(32'hFFFF_0000, 32'hFFFF_0000, "R1 hi x hi");
    drive(32'h0000_FFFF, 32'h0000_FFFF, "R1 lo x lo");
    idle(3);

    // R8 back-to-back random stream, then gapped stream
    for (int i = 0; i < 40; i++)
      drive($urandom, $urandom, "R8 back-to-back");
    for (int i = 0; i < 20; i++) begin
      drive($urandom, $urandom, "R1 gapped");
      idle(i % 3);
    end
    idle(4);

    // R4: reset while a pair is in flight drops it
    drive(32'h7777_7777, 32'h3333_3333, "R4 in flight");
    @(negedge clk);
    rst = 1'b1;
    op_a = 32'h1111_1111;
    exp_q.delete();
    due_q.delete();
    tag_q.delete();
    @(negedge clk);
    check(out_valid == 1'b0, "R4 cleared", 64'(out_valid), 64'd0);
    @(negedge clk);
    check(out_valid == 1'b0, "R4 held", 64'(out_valid), 64'd0);
    in_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R4 no stale 1", 64'(out_valid), 64'd0);
    @(negedge clk);
    check(out_valid == 1'b0, "R4 no stale 2", 64'(out_valid), 64'd0);

    // After reset the pipeline works again
    drive(32'hFFFF_FFFF, 32'h0000_0002, "R1 after reset");
    idle(5);
    check(exp_q.size() == 0, "R2 all results seen", 64'(exp_q.size()), 64'd0);
    finish_run();
  end

endmodule